// File: doc/BRIEF.md
# Floating-point exponent and shift-count datapath

This block is the exponent side of a floating-point unit that a sequencer drives one step at a time. It holds two 13-bit two's-complement registers. One is the result exponent. The other is the shift count that the mantissa datapath uses for alignment and normalization. On every clock the sequencer presents a control word. The control word picks two operands for each register, says which operand (if any) is negated, and says whether each register takes its new value. Each register is fed by its own adder. Negation is two's complement: the operand is inverted and the adder carry-in is set.

The operand sources are the exponents of three operands (A, B, C), a few fixed constants, and the current register contents. One further source, the "difference", is the result exponent minus the shift count, both taken from the registers before the edge. The shift count register has one extra path: it can load the count of leading zeros of a 64-bit mantissa word instead of its adder sum. That count reaches the register through its own multiplexer, not through the adder. All control and data pins are plain, level-sampled signals with no handshake. Every control word is consumed on the clock edge at which it is present.

Top module: `fpx_expshift`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the result exponent and the shift count to zero, whatever the control word is.
- R2: The first result-exponent operand is picked by `re_op1_sel`: 0 = current result exponent, 1 = A exponent, 2 = B exponent arithmetically shifted right by one, 3 = zero.
- R3: The second result-exponent operand is picked by `re_op2_sel`: 0 = current result exponent minus current shift count, 1 = B exponent, 2 = C exponent, 3 = the constant chosen by `re_kon_sel`.
- R4: The result-exponent constant picked by `re_kon_sel` is 0 for code 0, 56 for code 1, the maximum exponent +1023 for code 2, and the overflow trap bias 1536 for code 3.
- R5: Setting `*_op1_neg` or `*_op2_neg` subtracts that operand instead of adding it. A control word that sets both negate bits of the same adder is illegal.
- R6: When `re_load` is 0, the result exponent keeps its value. When it is 1, the register takes the adder sum.
- R7: The first shift operand is picked by `sh_op1_sel`: 0 = current result exponent minus current shift count, 1 = B exponent, 2 = current shift count, 3 = zero.
- R8: The second shift operand is the A exponent when `sh_op2_sel` is 0. When it is 1, the operand is the constant chosen by `sh_kon_sel`: codes 0..9 give 0, 1, 4, 8, 32, 52, 56, 63, 64 and the minimum exponent -1022; codes 10..15 give 0.
- R9: When `sh_take_clz` is 1, the shift count loads the number of leading zeros of `r_mant` in place of the adder sum. An all-zero `r_mant` gives 64, and a set bit 63 gives 0.
- R10: When `sh_hold` is 1, the shift count keeps its value. When it is 0, the register loads on every edge.
- R11: Both adders work modulo 2^13. A sum outside the signed 13-bit range wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_exp | input | 13 | Exponent of operand A, two's complement |
| b_exp | input | 13 | Exponent of operand B, two's complement |
| c_exp | input | 13 | Exponent of operand C, two's complement |
| r_mant | input | 64 | Mantissa word whose leading zeros are counted |
| re_op1_sel | input | 2 | First result-exponent operand select |
| re_op1_neg | input | 1 | Negate the first result-exponent operand |
| re_op2_sel | input | 2 | Second result-exponent operand select |
| re_op2_neg | input | 1 | Negate the second result-exponent operand |
| re_kon_sel | input | 2 | Result-exponent constant select |
| re_load | input | 1 | Load the result exponent |
| sh_op1_sel | input | 2 | First shift operand select |
| sh_op1_neg | input | 1 | Negate the first shift operand |
| sh_op2_sel | input | 1 | Second shift operand: A exponent or constant |
| sh_op2_neg | input | 1 | Negate the second shift operand |
| sh_kon_sel | input | 4 | Shift constant select |
| sh_take_clz | input | 1 | Load the leading-zero count instead of the sum |
| sh_hold | input | 1 | Keep the shift count |
| res_exp | output | 13 | Result exponent register |
| shift_amt | output | 13 | Shift count register |

## Verification
The bench builds the block with its default parameters: 13-bit exponents, a 64-bit mantissa word and the default exponent constants. With 13 bits, two in-range exponents of about 4000 can be added, which reaches the wraparound of R11. With 64 bits, the all-zero count of 64 and the top-bit count of 0 are exact boundary values. A chain of dependent vectors moves the registers through known values. This exercises the difference operand and the feedback operands with state left by the earlier steps, and not only from the reset state.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic [1:0] {
    RE1_RES   = 2'd0,
    RE1_AEXP  = 2'd1,
    RE1_BHALF = 2'd2,
    RE1_ZERO  = 2'd3
  } re_op1_e;

  typedef enum logic [1:0] {
    RE2_DIFF  = 2'd0,
    RE2_BEXP  = 2'd1,
    RE2_CEXP  = 2'd2,
    RE2_KON   = 2'd3
  } re_op2_e;

  typedef enum logic [1:0] {
    SH1_DIFF  = 2'd0,
    SH1_BEXP  = 2'd1,
    SH1_SHIFT = 2'd2,
    SH1_ZERO  = 2'd3
  } sh_op1_e;
endpackage

// File: rtl/fpx_addneg.sv
module fpx_addneg #(
  parameter int W = 13
) (
  input  logic [W-1:0] op1,
  input  logic [W-1:0] op2,
  input  logic         neg1,
  input  logic         neg2,
  output logic [W-1:0] sum
);
  logic [W-1:0] t1, t2, cin;

  assign t1  = op1 ^ {W{neg1}};
  assign t2  = op2 ^ {W{neg2}};
  assign cin = {{(W-1){1'b0}}, neg1 | neg2};
  assign sum = t1 + t2 + cin;
endmodule

// File: rtl/fpx_clz.sv
module fpx_clz #(
  parameter int W  = 64,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (val[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpx_expshift.sv
module fpx_expshift
  import fpx_pkg::*;
#(
  parameter int EXP_W     = 13,
  parameter int MANT_W    = 64,
  parameter int EXP_MAX   = 1023,
  parameter int EXP_MIN   = -1022,
  parameter int TRAP_BIAS = 1536
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXP_W-1:0] a_exp,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [EXP_W-1:0] c_exp,
  input  logic [MANT_W-1:0] r_mant,
  input  logic [1:0]       re_op1_sel,
  input  logic             re_op1_neg,
  input  logic [1:0]       re_op2_sel,
  input  logic             re_op2_neg,
  input  logic [1:0]       re_kon_sel,
  input  logic             re_load,
  input  logic [1:0]       sh_op1_sel,
  input  logic             sh_op1_neg,
  input  logic             sh_op2_sel,
  input  logic             sh_op2_neg,
  input  logic [3:0]       sh_kon_sel,
  input  logic             sh_take_clz,
  input  logic             sh_hold,
  output logic [EXP_W-1:0] res_exp,
  output logic [EXP_W-1:0] shift_amt
);
  localparam int CW = $clog2(MANT_W + 1);

  logic [EXP_W-1:0] res_q, sh_q, diff;
  logic [EXP_W-1:0] re_a, re_b, re_k, re_sum;
  logic [EXP_W-1:0] sh_a, sh_b, sh_k, sh_sum, sh_next;
  logic [CW-1:0]    lz;

  assign diff = res_q - sh_q;

  // result-exponent operand muxes
  always_comb begin
    unique case (re_kon_sel)
      2'd0:    re_k = '0;
      2'd1:    re_k = EXP_W'(56);
      2'd2:    re_k = EXP_W'(EXP_MAX);
      default: re_k = EXP_W'(TRAP_BIAS);
    endcase
    unique case (re_op1_e'(re_op1_sel))
      RE1_RES:   re_a = res_q;
      RE1_AEXP:  re_a = a_exp;
      RE1_BHALF: re_a = {b_exp[EXP_W-1], b_exp[EXP_W-1:1]};
      default:   re_a = '0;
    endcase
    unique case (re_op2_e'(re_op2_sel))
      RE2_DIFF: re_b = diff;
      RE2_BEXP: re_b = b_exp;
      RE2_CEXP: re_b = c_exp;
      default:  re_b = re_k;
    endcase
  end

  // shift operand muxes
  always_comb begin
    case (sh_kon_sel)
      4'd1:    sh_k = EXP_W'(1);
      4'd2:    sh_k = EXP_W'(4);
      4'd3:    sh_k = EXP_W'(8);
      4'd4:    sh_k = EXP_W'(32);
      4'd5:    sh_k = EXP_W'(52);
      4'd6:    sh_k = EXP_W'(56);
      4'd7:    sh_k = EXP_W'(63);
      4'd8:    sh_k = EXP_W'(64);
      4'd9:    sh_k = EXP_W'(EXP_MIN);
      default: sh_k = '0;
    endcase
    unique case (sh_op1_e'(sh_op1_sel))
      SH1_DIFF:  sh_a = diff;
      SH1_BEXP:  sh_a = b_exp;
      SH1_SHIFT: sh_a = sh_q;
      default:   sh_a = '0;
    endcase
    sh_b = sh_op2_sel ? sh_k : a_exp;
  end

  fpx_addneg #(.W(EXP_W)) u_re_add (
    .op1(re_a), .op2(re_b), .neg1(re_op1_neg), .neg2(re_op2_neg), .sum(re_sum)
  );

  fpx_addneg #(.W(EXP_W)) u_sh_add (
    .op1(sh_a), .op2(sh_b), .neg1(sh_op1_neg), .neg2(sh_op2_neg), .sum(sh_sum)
  );

  fpx_clz #(.W(MANT_W)) u_clz (.val(r_mant), .cnt(lz));

  // the leading-zero count joins after the adder
  assign sh_next = sh_take_clz ? EXP_W'(lz) : sh_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      sh_q  <= '0;
    end else begin
      if (re_load)  res_q <= re_sum;
      if (!sh_hold) sh_q  <= sh_next;
    end
  end

  assign res_exp   = res_q;
  assign shift_amt = sh_q;
endmodule

// File: rtl/fpx_expshift_chk.sv
module fpx_expshift_chk #(
  parameter int EXP_W  = 13,
  parameter int MANT_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [MANT_W-1:0] r_mant,
  input logic              re_op1_neg,
  input logic              re_op2_neg,
  input logic              re_load,
  input logic              sh_op1_neg,
  input logic              sh_op2_neg,
  input logic              sh_take_clz,
  input logic              sh_hold,
  input logic [EXP_W-1:0]  res_exp,
  input logic [EXP_W-1:0]  shift_amt
);
  // R5
  re_dual_neg_chk: assert property (@(posedge clk) disable iff (rst)
    !(re_op1_neg && re_op2_neg));

  // R5
  sh_dual_neg_chk: assert property (@(posedge clk) disable iff (rst)
    !(sh_op1_neg && sh_op2_neg));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_exp == '0 && shift_amt == '0));

  // R6
  re_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !re_load |=> $stable(res_exp));

  // R10
  sh_keep_chk: assert property (@(posedge clk) disable iff (rst)
    sh_hold |=> $stable(shift_amt));

  // R9
  clz_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (!sh_hold && sh_take_clz && r_mant == '0) |=> shift_amt == EXP_W'(MANT_W));

  // R9
  clz_top_chk: assert property (@(posedge clk) disable iff (rst)
    (!sh_hold && sh_take_clz && r_mant[MANT_W-1]) |=> shift_amt == '0);
endmodule

bind fpx_expshift fpx_expshift_chk #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_chk (.*);

// File: tb/tb_fpx_expshift.sv
`timescale 1ns/1ps
module tb_fpx_expshift;
  localparam int EW = 13;
  localparam int MW = 64;

  typedef struct packed {
    logic [1:0] r1s; logic r1n; logic [1:0] r2s; logic r2n; logic [1:0] rk; logic rld;
    logic [1:0] s1s; logic s1n; logic s2s; logic s2n; logic [3:0] sk; logic clz; logic hold;
    logic [EW-1:0] a; logic [EW-1:0] b; logic [EW-1:0] c; logic [MW-1:0] r;
    logic [EW-1:0] eres; logic [EW-1:0] esh; logic [7:0] tag;
  } vec_t;

  function automatic vec_t vec(int r1s, int r1n, int r2s, int r2n, int rk, int rld,
                               int s1s, int s1n, int s2s, int s2n, int sk, int clz, int hold,
                               int a, int b, int c, logic [MW-1:0] r,
                               int eres, int esh, int tag);
    vec_t v;
    v.r1s = 2'(r1s); v.r1n = 1'(r1n); v.r2s = 2'(r2s); v.r2n = 1'(r2n);
    v.rk = 2'(rk); v.rld = 1'(rld);
    v.s1s = 2'(s1s); v.s1n = 1'(s1n); v.s2s = 1'(s2s); v.s2n = 1'(s2n);
    v.sk = 4'(sk); v.clz = 1'(clz); v.hold = 1'(hold);
    v.a = EW'(a); v.b = EW'(b); v.c = EW'(c); v.r = r;
    v.eres = EW'(eres); v.esh = EW'(esh); v.tag = 8'(tag);
    return v;
  endfunction

  localparam int NV = 18;
  localparam vec_t V [NV] = '{
    vec(1,0,3,0,0,1, 3,0,1,0,0,0,1,  100,0,0,64'd0,  100,0, 2),      // R2 A + 0
    vec(3,0,3,0,1,1, 3,0,1,0,1,0,0,  0,0,0,64'd0,     56,1, 4),      // R4 56, R8 const 1
    vec(3,0,0,0,0,1, 2,0,1,0,2,0,0,  0,0,0,64'd0,     55,5, 3),      // R3 diff 56-1, R7 shift+4
    vec(2,0,2,0,0,1, 0,0,1,0,3,0,0,  0,-7,10,64'd0,   6,58, 3),      // R2 B>>>1, R3 C, R7 diff+8
    vec(0,0,1,1,0,1, 1,0,0,1,0,0,0,  3,20,0,64'd0,    -14,17, 5),    // R5 negate second
    vec(1,1,3,0,2,1, 2,1,1,0,4,0,0,  5,0,0,64'd0,     1018,15, 5),   // R5 negate first, max
    vec(3,0,3,0,3,1, 3,0,1,0,5,0,0,  0,0,0,64'd0,     1536,52, 4),   // R4 trap bias
    vec(1,0,3,0,0,0, 3,0,1,0,6,0,0,  999,0,0,64'd0,   1536,56, 6),   // R6 no load
    vec(1,0,3,0,0,0, 3,0,1,0,7,0,0,  0,0,0,64'd0,     1536,63, 8),   // R8 63
    vec(1,0,3,0,0,0, 3,0,1,0,8,0,0,  0,0,0,64'd0,     1536,64, 8),   // R8 64
    vec(1,0,3,0,0,0, 3,0,1,0,9,0,0,  0,0,0,64'd0,     1536,-1022, 8),// R8 min exponent
    vec(1,0,3,0,0,0, 3,0,1,0,12,0,0, 0,0,0,64'd0,     1536,0, 8),    // R8 unused code
    vec(1,0,3,0,0,0, 3,0,1,0,1,1,0,  0,0,0,64'h1_0000_0000, 1536,31, 9), // R9
    vec(1,0,3,0,0,0, 3,0,1,0,1,1,0,  0,0,0,64'd0,     1536,64, 9),   // R9 all zero
    vec(1,0,3,0,0,0, 3,0,1,0,1,1,0,  0,0,0,64'h8000_0000_0000_0000, 1536,0, 9), // R9 top bit
    vec(1,0,3,0,0,0, 3,0,1,0,1,1,1,  0,0,0,64'd0,     1536,0, 10),   // R10 hold
    vec(1,0,1,0,0,1, 3,0,1,0,0,0,1,  4000,4000,0,64'd0, -192,0, 11), // R11 wrap
    vec(3,0,2,1,0,1, 3,0,1,0,0,0,1,  0,0,-4095,64'd0, 4095,0, 5)     // R5 negate C
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [EW-1:0] a_exp, b_exp, c_exp;
  logic [MW-1:0] r_mant;
  logic [1:0] re_op1_sel, re_op2_sel, re_kon_sel, sh_op1_sel;
  logic re_op1_neg, re_op2_neg, re_load, sh_op1_neg, sh_op2_sel, sh_op2_neg;
  logic [3:0] sh_kon_sel;
  logic sh_take_clz, sh_hold;
  logic [EW-1:0] res_exp, shift_amt;
  int applied = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fpx_expshift dut (
    .clk(clk), .rst(rst), .a_exp(a_exp), .b_exp(b_exp), .c_exp(c_exp), .r_mant(r_mant),
    .re_op1_sel(re_op1_sel), .re_op1_neg(re_op1_neg), .re_op2_sel(re_op2_sel),
    .re_op2_neg(re_op2_neg), .re_kon_sel(re_kon_sel), .re_load(re_load),
    .sh_op1_sel(sh_op1_sel), .sh_op1_neg(sh_op1_neg), .sh_op2_sel(sh_op2_sel),
    .sh_op2_neg(sh_op2_neg), .sh_kon_sel(sh_kon_sel), .sh_take_clz(sh_take_clz),
    .sh_hold(sh_hold), .res_exp(res_exp), .shift_amt(shift_amt)
  );

  task automatic drive(input vec_t v);
    re_op1_sel = v.r1s; re_op1_neg = v.r1n; re_op2_sel = v.r2s; re_op2_neg = v.r2n;
    re_kon_sel = v.rk;  re_load = v.rld;
    sh_op1_sel = v.s1s; sh_op1_neg = v.s1n; sh_op2_sel = v.s2s; sh_op2_neg = v.s2n;
    sh_kon_sel = v.sk;  sh_take_clz = v.clz; sh_hold = v.hold;
    a_exp = v.a; b_exp = v.b; c_exp = v.c; r_mant = v.r;
  endtask

  task automatic check(input int tag, input logic [EW-1:0] er, input logic [EW-1:0] es);
    applied++;
    if (res_exp !== er || shift_amt !== es) begin
      bad++;
      $display("FAIL R%0d: res_exp=%0d shift_amt=%0d, expected res_exp=%0d shift_amt=%0d",
               tag, $signed(res_exp), $signed(shift_amt), $signed(er), $signed(es));
    end
  endtask

  initial begin
    drive(vec(1,0,3,0,0,1, 3,0,1,0,1,0,0, 7,0,0,64'd0, 0,0,1));
    repeat (3) @(negedge clk);
    check(1, '0, '0);                                      // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(V[i]);
      @(negedge clk);
      check(int'(V[i].tag), V[i].eres, V[i].esh);
    end
    // R1: reset mid-run overrides an active load
    drive(vec(1,0,3,0,0,1, 3,0,1,0,7,0,0, 7,0,0,64'd0, 0,0,1));
    rst = 1'b1;
    @(negedge clk);
    check(1, '0, '0);
    rst = 1'b0;
    @(negedge clk);
    check(2, EW'(7), EW'(63));                             // R2 recovery after reset
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule